// File: doc/BRIEF.md
# Hardware Cursor Overlay (32 x 32, 2 bits per dot)

This block lays a small square cursor image over a raster pixel stream. Each incoming pixel arrives with its horizontal and vertical counter values. When the counters fall inside the cursor window, a 2-bit code from the stored bitmap decides what the output pixel becomes. The pixel can pass through unchanged, be replaced by one of two programmable colours, or have every bit inverted. A one-bit mode input swaps which codes mean "pass" and "invert". Outside the window the pixel passes through untouched. Every output is registered, and the sync and data-enable flags are delayed by the same single clock.

The bitmap holds 32 x 32 dots at 2 bits each, so it is 256 bytes. There are two ways to fill it. The first is a simple byte-wide register write port. The second is an in-band loader that watches a byte stream. When the loader is enabled, a marker flags the final colour-table byte. The 256 valid bytes that follow are captured in order as the bitmap. The block does not work out where the cursor should be: the position comes in on input ports.

Top module: `cursor_overlay`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `px_o`, `hsync_o`, `vsync_o` and `de_o` at zero.
- R2: `hsync_o`, `vsync_o` and `de_o` equal the values `hsync_i`, `vsync_i` and `de_i` had one clock earlier. `px_o` is likewise the result for the pixel presented one clock earlier.
- R3: A pixel whose horizontal count is outside `cur_x_i`..`cur_x_i`+31, or whose vertical count is outside `cur_y_i`..`cur_y_i`+31, leaves unchanged. The comparison does not wrap: a window starting near the counter maximum does not reappear at count 0.
- R4: Inside the window, column c = hcnt - cur_x and row r = vcnt - cur_y select bitmap byte r*8 + c/4. Within that byte the 2-bit code sits at bits 2*(c%4)+1 : 2*(c%4), so column 0 uses bits 1:0. Position (0,0) is the upper-left dot.
- R5: With `cur_mode_i` = 0, the codes map as follows: 00 passes the input pixel, 01 gives `color1_i`, 10 gives `color2_i`, and 11 gives the bitwise inverse of the input pixel.
- R6: With `cur_mode_i` = 1, code 00 gives the inverted input pixel and code 11 passes the input pixel. Codes 01 and 10 still select `color1_i` and `color2_i`.
- R7: A clock edge with `reg_we_i` high stores `reg_wdata_i` into bitmap byte `reg_addr_i`.
- R8: With `ib_load_en_i` high, a valid stream byte with `sb_lut_last_i` high arms the loader. That byte itself is not stored. The next 256 bytes with `sb_valid_i` high are stored at addresses 0 to 255 in arrival order, with idle cycles allowed between them. Loading then stops, and later stream bytes change nothing.
- R9: While the loader is idle and `ib_load_en_i` is low, stream traffic, including marked bytes, leaves the bitmap unchanged.
- R10: When a stream byte is being stored in the same cycle as a register write, the stream byte is stored and the register write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_i | input | PIX_W | Input pixel |
| hcnt_i | input | CNT_W | Horizontal count of `px_i` |
| vcnt_i | input | CNT_W | Vertical count of `px_i` |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in |
| de_i | input | 1 | Data enable in |
| cur_x_i | input | CNT_W | Cursor left column |
| cur_y_i | input | CNT_W | Cursor top row |
| cur_mode_i | input | 1 | Code interpretation select |
| color1_i | input | PIX_W | Cursor colour one |
| color2_i | input | PIX_W | Cursor colour two |
| reg_we_i | input | 1 | Bitmap register write strobe |
| reg_addr_i | input | ADDR_W | Bitmap register byte address |
| reg_wdata_i | input | 8 | Bitmap register write data |
| ib_load_en_i | input | 1 | Allows the in-band loader to arm |
| sb_valid_i | input | 1 | Stream byte valid |
| sb_lut_last_i | input | 1 | Marks the last colour-table byte |
| sb_data_i | input | 8 | Stream byte |
| px_o | output | PIX_W | Composited pixel |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |
| de_o | output | 1 | Delayed data enable |

## Verification
Every output is due exactly one clock after the pixel, counters and control values are sampled. A bitmap write takes effect for pixels sampled at the edge after the write edge. The pixel being composited at the write edge still sees the old byte. The bench's reference model works through the same timeline at each rising edge: it first computes the expected output from the bitmap as it stood, and only then applies that edge's writes. Outputs are compared at the following falling edge, and inputs change one nanosecond after it, so no comparison races the design's register update.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;

  typedef enum logic [1:0] {
    SEL_PASS = 2'd0,
    SEL_COL1 = 2'd1,
    SEL_COL2 = 2'd2,
    SEL_INV  = 2'd3
  } sel_e;

  typedef enum logic {
    UP_IDLE = 1'b0,
    UP_LOAD = 1'b1
  } up_state_e;

  // Translate a dot code into a pixel source, given the mode bit.
  function automatic sel_e code_to_sel(input logic mode, input logic [1:0] code);
    sel_e s;
    unique case (code)
      2'b01:   s = SEL_COL1;
      2'b10:   s = SEL_COL2;
      2'b00:   s = mode ? SEL_INV  : SEL_PASS;
      default: s = mode ? SEL_PASS : SEL_INV;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cursor_bitmap.sv
module cursor_bitmap #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              s_we,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [7:0]        s_data,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [7:0]        r_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  logic [7:0] mem [DEPTH];

  // Single write port; stream traffic takes precedence (R10).
  always_ff @(posedge clk) begin
    if (s_we) begin
      mem[s_addr] <= s_data;
    end else if (r_we) begin
      mem[r_addr] <= r_data;
    end
  end

  // Asynchronous read keeps the overlay at one clock of latency.
  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cursor_upload.sv
module cursor_upload
  import cursor_overlay_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              sb_valid,
  input  logic              sb_lut_last,
  input  logic [7:0]        sb_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  up_state_e         state;
  logic [ADDR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= UP_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        UP_IDLE: begin
          if (enable && sb_valid && sb_lut_last) begin
            state <= UP_LOAD;
            cnt   <= '0;
          end
        end
        default: begin
          if (sb_valid) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_ADDR) begin
              state <= UP_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign wr_en   = (state == UP_LOAD) && sb_valid;
  assign wr_addr = cnt;
  assign wr_data = sb_data;

endmodule

// File: rtl/cursor_window.sv
module cursor_window #(
  parameter int CNT_W   = 12,
  parameter int CUR_DIM = 32,
  parameter int ADDR_W  = 8
) (
  input  logic [CNT_W-1:0]  hcnt,
  input  logic [CNT_W-1:0]  vcnt,
  input  logic [CNT_W-1:0]  pos_x,
  input  logic [CNT_W-1:0]  pos_y,
  output logic              hit,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        dot_sel
);

  localparam int COL_W = $clog2(CUR_DIM);

  logic [CNT_W:0]   dh, dv;
  logic             hit_h, hit_v;
  logic [COL_W-1:0] col, row;

  // Extra top bit catches count < position, so the window never wraps.
  assign dh = {1'b0, hcnt} - {1'b0, pos_x};
  assign dv = {1'b0, vcnt} - {1'b0, pos_y};

  assign hit_h = !dh[CNT_W] && (dh[CNT_W-1:COL_W] == '0);
  assign hit_v = !dv[CNT_W] && (dv[CNT_W-1:COL_W] == '0);
  assign hit   = hit_h && hit_v;

  assign col = dh[COL_W-1:0];
  assign row = dv[COL_W-1:0];

  // Row-major byte order, four dots per byte from the LSB upward.
  assign rd_addr = {row, col[COL_W-1:2]};
  assign dot_sel = col[1:0];

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_overlay_pkg::*;
#(
  parameter  int PIX_W   = 24,
  parameter  int CNT_W   = 12,
  parameter  int CUR_DIM = 32,
  localparam int DEPTH   = CUR_DIM * CUR_DIM / 4,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  px_i,
  input  logic [CNT_W-1:0]  hcnt_i,
  input  logic [CNT_W-1:0]  vcnt_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              de_i,
  input  logic [CNT_W-1:0]  cur_x_i,
  input  logic [CNT_W-1:0]  cur_y_i,
  input  logic              cur_mode_i,
  input  logic [PIX_W-1:0]  color1_i,
  input  logic [PIX_W-1:0]  color2_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              ib_load_en_i,
  input  logic              sb_valid_i,
  input  logic              sb_lut_last_i,
  input  logic [7:0]        sb_data_i,
  output logic [PIX_W-1:0]  px_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o
);

  logic              up_we;
  logic [ADDR_W-1:0] up_addr;
  logic [7:0]        up_data;
  logic              win_hit;
  logic [ADDR_W-1:0] win_addr;
  logic [1:0]        win_dot;
  logic [7:0]        bm_byte;
  logic [1:0]        dot_code;
  sel_e              sel;

  cursor_upload #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_upload (
    .clk         (clk),
    .rst         (rst),
    .enable      (ib_load_en_i),
    .sb_valid    (sb_valid_i),
    .sb_lut_last (sb_lut_last_i),
    .sb_data     (sb_data_i),
    .wr_en       (up_we),
    .wr_addr     (up_addr),
    .wr_data     (up_data)
  );

  cursor_bitmap #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bitmap (
    .clk     (clk),
    .s_we    (up_we),
    .s_addr  (up_addr),
    .s_data  (up_data),
    .r_we    (reg_we_i),
    .r_addr  (reg_addr_i),
    .r_data  (reg_wdata_i),
    .rd_addr (win_addr),
    .rd_data (bm_byte)
  );

  cursor_window #(.CNT_W(CNT_W), .CUR_DIM(CUR_DIM), .ADDR_W(ADDR_W)) u_window (
    .hcnt    (hcnt_i),
    .vcnt    (vcnt_i),
    .pos_x   (cur_x_i),
    .pos_y   (cur_y_i),
    .hit     (win_hit),
    .rd_addr (win_addr),
    .dot_sel (win_dot)
  );

  assign dot_code = bm_byte[{win_dot, 1'b0} +: 2];
  assign sel      = win_hit ? code_to_sel(cur_mode_i, dot_code) : SEL_PASS;

  always_ff @(posedge clk) begin
    if (rst) begin
      px_o    <= '0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
    end else begin
      unique case (sel)
        SEL_COL1: px_o <= color1_i;
        SEL_COL2: px_o <= color2_i;
        SEL_INV:  px_o <= ~px_i;
        default:  px_o <= px_i;
      endcase
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
      de_o    <= de_i;
    end
  end

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int PIX_W   = 24,
  parameter int CNT_W   = 12,
  parameter int CUR_DIM = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [PIX_W-1:0] px_i,
  input logic [CNT_W-1:0] hcnt_i,
  input logic [CNT_W-1:0] vcnt_i,
  input logic             hsync_i,
  input logic             vsync_i,
  input logic             de_i,
  input logic [CNT_W-1:0] cur_x_i,
  input logic [CNT_W-1:0] cur_y_i,
  input logic [PIX_W-1:0] color1_i,
  input logic [PIX_W-1:0] color2_i,
  input logic [PIX_W-1:0] px_o,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             de_o
);

  logic in_win;
  always_comb begin
    in_win = (int'(hcnt_i) >= int'(cur_x_i)) && (int'(hcnt_i) <= int'(cur_x_i) + CUR_DIM - 1) &&
             (int'(vcnt_i) >= int'(cur_y_i)) && (int'(vcnt_i) <= int'(cur_y_i) + CUR_DIM - 1);
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (px_o == '0 && !hsync_o && !vsync_o && !de_o));

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hsync_o == $past(hsync_i) && vsync_o == $past(vsync_i) && de_o == $past(de_i)));

  // R3
  outside_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_win)) |-> (px_o == $past(px_i)));

  // R5
  legal_source_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (px_o == $past(px_i) || px_o == ~$past(px_i) ||
                     px_o == $past(color1_i) || px_o == $past(color2_i)));

endmodule

bind cursor_overlay cursor_overlay_chk #(.PIX_W(PIX_W), .CNT_W(CNT_W), .CUR_DIM(CUR_DIM)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .px_i     (px_i),
  .hcnt_i   (hcnt_i),
  .vcnt_i   (vcnt_i),
  .hsync_i  (hsync_i),
  .vsync_i  (vsync_i),
  .de_i     (de_i),
  .cur_x_i  (cur_x_i),
  .cur_y_i  (cur_y_i),
  .color1_i (color1_i),
  .color2_i (color2_i),
  .px_o     (px_o),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .de_o     (de_o)
);

// File: tb/cursor_overlay_test.sv
`timescale 1ns/1ps
module cursor_overlay_test;

  localparam int PIX_W = 24;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [PIX_W-1:0] px_i = '0;
  logic [CNT_W-1:0] hcnt_i = '0, vcnt_i = '0;
  logic             hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
  logic [CNT_W-1:0] cur_x_i = 12'd2000, cur_y_i = 12'd2000;
  logic             cur_mode_i = 1'b0;
  logic [PIX_W-1:0] color1_i = 24'hF0A050, color2_i = 24'h0C3399;
  logic             reg_we_i = 1'b0;
  logic [7:0]       reg_addr_i = '0, reg_wdata_i = '0;
  logic             ib_load_en_i = 1'b0, sb_valid_i = 1'b0, sb_lut_last_i = 1'b0;
  logic [7:0]       sb_data_i = '0;
  logic [PIX_W-1:0] px_o;
  logic             hsync_o, vsync_o, de_o;

  always #2.5 clk = ~clk;

  cursor_overlay uut (
    .clk(clk), .rst(rst), .px_i(px_i), .hcnt_i(hcnt_i), .vcnt_i(vcnt_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i), .cur_x_i(cur_x_i), .cur_y_i(cur_y_i),
    .cur_mode_i(cur_mode_i), .color1_i(color1_i), .color2_i(color2_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .ib_load_en_i(ib_load_en_i),
    .sb_valid_i(sb_valid_i), .sb_lut_last_i(sb_lut_last_i), .sb_data_i(sb_data_i),
    .px_o(px_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o)
  );

  int    checks = 0, fails = 0;
  string phase = "R1";
  bit    done = 1'b0;

  // Behavioural reference model.
  int         ref_mem [256];
  bit         ld_active = 1'b0;
  int         ld_count = 0;
  logic [23:0] e_px = '0;
  logic       e_hs = 1'b0, e_vs = 1'b0, e_de = 1'b0;
  string      e_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      e_px = '0; e_hs = 0; e_vs = 0; e_de = 0; e_tag = "R1";
      ld_active = 0; ld_count = 0;
    end else begin
      int h, v, cx, cy, c, r, code;
      h = hcnt_i; v = vcnt_i; cx = cur_x_i; cy = cur_y_i;
      if (h >= cx && h < cx + 32 && v >= cy && v < cy + 32) begin
        c = h - cx; r = v - cy;
        code = (ref_mem[r * 8 + c / 4] >> (2 * (c % 4))) & 3;
        e_tag = cur_mode_i ? "R6" : "R5";
        if (code == 1) e_px = color1_i;
        else if (code == 2) e_px = color2_i;
        else if ((code == 3) != cur_mode_i) e_px = ~px_i;
        else e_px = px_i;
      end else begin
        e_tag = "R3";
        e_px = px_i;
      end
      e_hs = hsync_i; e_vs = vsync_i; e_de = de_i;
      if (ld_active && sb_valid_i) ref_mem[ld_count] = sb_data_i;
      else if (reg_we_i) ref_mem[reg_addr_i] = reg_wdata_i;
      if (ld_active) begin
        if (sb_valid_i) begin
          ld_count++;
          if (ld_count == 256) ld_active = 0;
        end
      end else if (ib_load_en_i && sb_valid_i && sb_lut_last_i) begin
        ld_active = 1; ld_count = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (px_o !== e_px) begin
        fails++;
        $display("FAIL %s (phase %s): px_o actual %h expected %h", e_tag, phase, px_o, e_px);
      end
      checks++;
      if ({hsync_o, vsync_o, de_o} !== {e_hs, e_vs, e_de}) begin
        fails++;
        $display("FAIL R2 (phase %s): syncs actual %b expected %b", phase,
                 {hsync_o, vsync_o, de_o}, {e_hs, e_vs, e_de});
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic sweep(input int x0, input int x1, input int y0, input int y1);
    for (int v = y0; v <= y1; v++) begin
      for (int h = x0; h <= x1; h++) begin
        step();
        hcnt_i = CNT_W'(h); vcnt_i = CNT_W'(v);
        px_i = {8'(v * 5 + 3), 8'(h), 8'(h ^ (v * 11))};
        hsync_i = (h % 64) < 4; vsync_i = v < 2; de_i = (h % 64) < 56;
      end
    end
  endtask

  task automatic sbyte(input bit vld, input bit last, input logic [7:0] d,
                       input bit we, input logic [7:0] wa, input logic [7:0] wd);
    step();
    sb_valid_i = vld; sb_lut_last_i = last; sb_data_i = d;
    reg_we_i = we; reg_addr_i = wa; reg_wdata_i = wd;
  endtask

  task automatic sidle();
    sbyte(0, 0, 8'h00, 0, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset values.
    repeat (4) step();
    rst = 1'b0;
    // R7: fill bitmap through registers.
    phase = "R7";
    for (int a = 0; a < 256; a++) sbyte(0, 0, 8'h00, 1, 8'(a), 8'((a * 37 + 11) & 255));
    sidle();
    // R4/R5: mode 0 raster.
    phase = "R4";
    cur_x_i = 12'd10; cur_y_i = 12'd5;
    sweep(0, 63, 0, 47);
    // R6: mode 1 raster.
    phase = "R6";
    cur_mode_i = 1'b1;
    sweep(0, 63, 0, 47);
    cur_mode_i = 1'b0;
    // R4: window at origin.
    phase = "R4";
    cur_x_i = 12'd0; cur_y_i = 12'd0;
    sweep(0, 40, 0, 35);
    // R3: window near counter maximum, no wrap to zero.
    phase = "R3";
    cur_x_i = 12'd4080; cur_y_i = 12'd0;
    sweep(4070, 4095, 0, 2);
    sweep(0, 40, 0, 2);
    // R9: stream ignored with loader disabled.
    phase = "R9";
    cur_x_i = 12'd0; cur_y_i = 12'd0;
    sbyte(1, 1, 8'hAA, 0, 8'h00, 8'h00);
    for (int i = 0; i < 260; i++) sbyte(1, 0, 8'h55, 0, 8'h00, 8'h00);
    sidle();
    sweep(0, 35, 0, 33);
    // R8/R10: in-band load with gaps and colliding register writes.
    phase = "R8";
    ib_load_en_i = 1'b1;
    sbyte(1, 0, 8'h77, 0, 8'h00, 8'h00);
    sbyte(1, 1, 8'h99, 0, 8'h00, 8'h00);
    for (int i = 0; i < 256; i++) begin
      if (i % 17 == 5) sbyte(0, 0, 8'h00, 1, 8'(255 - i), 8'hC3);
      if (i % 29 == 7) sbyte(1, 0, 8'((i * 73 + 5) & 255), 1, 8'(i), 8'h3C);
      else sbyte(1, 0, 8'((i * 73 + 5) & 255), 0, 8'h00, 8'h00);
    end
    for (int i = 0; i < 10; i++) sbyte(1, i == 3, 8'hE1, 0, 8'h00, 8'h00);
    sidle();
    ib_load_en_i = 1'b0;
    phase = "R10";
    sweep(0, 35, 0, 33);
    cur_mode_i = 1'b1;
    phase = "R8";
    sweep(0, 35, 0, 33);
    // R1: reset mid-stream.
    phase = "R1";
    rst = 1'b1;
    sweep(0, 3, 0, 0);
    rst = 1'b0;
    sweep(0, 3, 0, 0);
    step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule